// File: doc/BRIEF.md
# Command-Driven Generic DMA Port

This block joins an on-chip endpoint buffer to an external data bus that an outside DMA master controls. A microcontroller starts, stops or marks transfers by writing a single opcode byte. Once a transfer runs, the block raises its request line whenever the buffer can take a word or has a word to give. The external master answers with its acknowledge line and a strobe for each data beat: the write strobe carries a word into the buffer, and the read strobe takes a word out of it. Each of the two directions has its own strobe.

Static configuration inputs select an 8-bit or 16-bit bus, an optional byte exchange in 16-bit mode, the active level of every handshake pin and of the end-of-transfer pin, and whether a beat counter limits the transfer. A transfer ends when the counter expires, when the external end-of-transfer pin is seen, or when a stop opcode arrives. Three sticky flags record how it ended.

The buffer side is valid/ready. Toward the buffer, `buf_in_valid` marks a beat offered by the bus. It does not wait on `buf_in_ready`. The block keeps its request inactive while the buffer is full, and a strobe given without ready is dropped. From the buffer, a word moves when `buf_out_valid` and `buf_out_ready` are both high in the same cycle. `buf_out_data` must stay stable while valid is high and ready is low. All pins are sampled on the block clock, and each strobe pulse lasts one clock.

Top module: `gdma_port`

## Requirements
- R1: The command register is write-only, and `cmd_rdata` always reads 8'hFF.
- R2: Opcode 8'h00 starts a bus-to-buffer transfer. In each cycle where the transfer is active, acknowledge is active and the write strobe is active, `buf_in_valid` is high with the formatted bus word. The beat counts only if `buf_in_ready` is high.
- R3: Opcode 8'h01 starts a buffer-to-bus transfer. `buf_out_ready` is high exactly in the active cycles where acknowledge and the read strobe are both active. The beat counts only if `buf_out_valid` is high.
- R4: Opcodes 8'h02 through 8'h0D change nothing: no state, no output and no flag.
- R5: Opcode 8'h0E pulses `buf_validate` for exactly the one cycle after the write and has no other effect.
- R6: Opcode 8'h0F ends an active transfer in the next cycle. The request goes inactive, `dma_d_oe` goes low and no flag is set.
- R7: `dma_d_oe` is low from reset until a transfer command has been accepted. After that it is high only while a buffer-to-bus transfer is active.
- R8: When `cfg_wide`=0, only bits 7:0 carry data and bits 15:8 of the formatted word are zero, whatever `cfg_swap` is. When `cfg_wide`=1 and `cfg_swap`=1, the two bytes are exchanged in both directions.
- R9: Each polarity input set to 1 makes its pin active-high, and set to 0 makes it active-low. This covers request, acknowledge, read strobe, write strobe and end-of-transfer.
- R10: When the counter is enabled, the transfer ends in the cycle after the beat numbered `xfer_count`, and that cycle sets `irq_int_eot` and `irq_xfer_ok`. A count of zero ends the transfer at once, with the same two flags set.
- R11: When `cfg_no_count`=1, beats never end the transfer. Only the end-of-transfer pin or a stop command ends it.
- R12: An active end-of-transfer pin during a transfer ends it in the next cycle and sets `irq_ext_eot` and `irq_xfer_ok`. It does this together with `irq_int_eot` if the last counted beat falls in the same cycle.
- R13: The request is active exactly when a transfer is running and either the buffer is ready (bus-to-buffer) or the buffer has valid data (buffer-to-bus).
- R14: The three flags are sticky. Only an accepted 8'h00 or 8'h01 command clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Opcode written |
| cmd_rdata | output | 8 | Read value of the command register (always FFh) |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_swap | input | 1 | Exchange bytes in 16-bit mode |
| cfg_no_count | input | 1 | Disable the beat counter |
| cfg_pol_ack | input | 1 | Acknowledge active level |
| cfg_pol_req | input | 1 | Request active level |
| cfg_pol_rd | input | 1 | Read strobe active level |
| cfg_pol_wr | input | 1 | Write strobe active level |
| cfg_pol_eot | input | 1 | End-of-transfer active level |
| xfer_count | input | CNT_W | Beats per transfer, loaded at start |
| dma_req | output | 1 | Request to the external master |
| dma_ack | input | 1 | Acknowledge from the master |
| dma_rd_stb | input | 1 | Master read strobe (buffer to bus) |
| dma_wr_stb | input | 1 | Master write strobe (bus to buffer) |
| dma_eot | input | 1 | External end-of-transfer |
| dma_d_in | input | 2*BYTE_W | Bus data in |
| dma_d_out | output | 2*BYTE_W | Bus data out |
| dma_d_oe | output | 1 | Bus output enable (0 = high impedance) |
| buf_in_valid | output | 1 | Word offered to the buffer |
| buf_in_ready | input | 1 | Buffer has space |
| buf_in_data | output | 2*BYTE_W | Word into the buffer |
| buf_out_valid | input | 1 | Buffer has a word |
| buf_out_ready | output | 1 | Word taken from the buffer |
| buf_out_data | input | 2*BYTE_W | Word from the buffer |
| buf_validate | output | 1 | One-cycle buffer-valid pulse |
| irq_int_eot | output | 1 | Ended by counter |
| irq_ext_eot | output | 1 | Ended by external pin |
| irq_xfer_ok | output | 1 | Transfer completed |

## Verification
The hardest case to reach is the one where the last counted beat and the external end-of-transfer pin arrive in the same cycle. The flags from both causes must then appear together, and the decrement must not be lost. The bench first runs the buffer ready and valid without a break, so it knows the exact cycle of the final beat, and it asserts the pin in that same cycle. A later random phase mixes polarities, opcodes, buffer stalls, pin pulses and commands that land in the middle of a transfer. A behavioural model checks every cycle of that phase.

// File: rtl/gdma_pkg.sv
package gdma_pkg;

  typedef enum logic [7:0] {
    OP_BUS2BUF = 8'h00,
    OP_BUF2BUS = 8'h01,
    OP_VALID   = 8'h0E,
    OP_STOP    = 8'h0F
  } gdma_op_e;

  localparam logic [7:0] RSV_LO = 8'h02;
  localparam logic [7:0] RSV_HI = 8'h0D;

  // Turn a pin level into "active" using its configured active level.
  function automatic logic pin_active(input logic pin, input logic active_high);
    return active_high ? pin : ~pin;
  endfunction

endpackage

// File: rtl/gdma_beat_counter.sv
module gdma_beat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain <= '0;
    else if (load)   remain <= load_val;
    else if (dec)    remain <= remain - CNT_W'(1);
  end

  assign last = (remain == CNT_W'(1));

  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> remain == $past(load_val));

endmodule

// File: rtl/gdma_sequencer.sv
module gdma_sequencer
  import gdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_op,
  input  logic       cnt_en,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  input  logic       beat,
  input  logic       eot_act,
  output logic       busy,
  output logic       dir_wr,
  output logic       cnt_load,
  output logic       irq_int,
  output logic       irq_ext,
  output logic       irq_ok,
  output logic       validate
);

  logic is_start, is_stop, is_valid, term_cnt, term_ext, instant_end;

  assign is_start    = cmd_wr && (cmd_op == OP_BUS2BUF || cmd_op == OP_BUF2BUS);
  assign is_stop     = cmd_wr && (cmd_op == OP_STOP);
  assign is_valid    = cmd_wr && (cmd_op == OP_VALID);
  assign instant_end = cnt_en && cnt_zero;
  assign term_cnt    = busy && beat && cnt_en && cnt_last;
  assign term_ext    = busy && eot_act;
  assign cnt_load    = is_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      dir_wr   <= 1'b0;
      irq_int  <= 1'b0;
      irq_ext  <= 1'b0;
      irq_ok   <= 1'b0;
      validate <= 1'b0;
    end else begin
      validate <= is_valid;
      if (is_start) begin
        busy    <= !instant_end;
        dir_wr  <= cmd_op[0];
        irq_int <= instant_end;
        irq_ext <= 1'b0;
        irq_ok  <= instant_end;
      end else if (is_stop) begin
        busy <= 1'b0;
      end else if (term_cnt || term_ext) begin
        busy    <= 1'b0;
        irq_ok  <= 1'b1;
        if (term_cnt) irq_int <= 1'b1;
        if (term_ext) irq_ext <= 1'b1;
      end
    end
  end

  assert_stop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_stop |=> !busy && $stable({irq_int, irq_ext, irq_ok}));

  assert_reserved_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_op >= RSV_LO && cmd_op <= RSV_HI && !busy
      |=> !busy && $stable({irq_int, irq_ext, irq_ok}));

  assert_count_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt && !cmd_wr |=> !busy && irq_int && irq_ok);

  assert_ext_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    term_ext && !cmd_wr |=> !busy && irq_ext && irq_ok);

  assert_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ext || irq_int || irq_ok) && !is_start
      |=> (irq_ext >= $past(irq_ext)) && (irq_int >= $past(irq_int)) && (irq_ok >= $past(irq_ok)));

endmodule

// File: rtl/gdma_bus_if.sv
module gdma_bus_if
  import gdma_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic                dir_wr,
  input  logic                cfg_wide,
  input  logic                cfg_swap,
  input  logic                cfg_pol_ack,
  input  logic                cfg_pol_req,
  input  logic                cfg_pol_rd,
  input  logic                cfg_pol_wr,
  input  logic                cfg_pol_eot,
  input  logic                dma_ack,
  input  logic                dma_rd_stb,
  input  logic                dma_wr_stb,
  input  logic                dma_eot,
  input  logic [2*BYTE_W-1:0] dma_d_in,
  output logic                dma_req,
  output logic [2*BYTE_W-1:0] dma_d_out,
  output logic                dma_d_oe,
  input  logic                buf_in_ready,
  output logic                buf_in_valid,
  output logic [2*BYTE_W-1:0] buf_in_data,
  input  logic                buf_out_valid,
  input  logic [2*BYTE_W-1:0] buf_out_data,
  output logic                buf_out_ready,
  output logic                beat,
  output logic                eot_act
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * BYTE_W;

  logic ack_a, rd_a, wr_a, req_a;
  logic [DATA_W-1:0] in_swap, out_swap, in_fmt, out_fmt;

  assign ack_a   = pin_active(dma_ack,    cfg_pol_ack);
  assign rd_a    = pin_active(dma_rd_stb, cfg_pol_rd);
  assign wr_a    = pin_active(dma_wr_stb, cfg_pol_wr);
  assign eot_act = pin_active(dma_eot,    cfg_pol_eot);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign in_swap[g*BYTE_W +: BYTE_W]  = dma_d_in[(LANES-1-g)*BYTE_W +: BYTE_W];
    assign out_swap[g*BYTE_W +: BYTE_W] = buf_out_data[(LANES-1-g)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (!cfg_wide) begin
      in_fmt  = {{BYTE_W{1'b0}}, dma_d_in[BYTE_W-1:0]};
      out_fmt = {{BYTE_W{1'b0}}, buf_out_data[BYTE_W-1:0]};
    end else if (cfg_swap) begin
      in_fmt  = in_swap;
      out_fmt = out_swap;
    end else begin
      in_fmt  = dma_d_in;
      out_fmt = buf_out_data;
    end
  end

  // Stream toward the buffer (bus-to-buffer direction).
  assign buf_in_valid  = busy && !dir_wr && ack_a && wr_a;
  assign buf_in_data   = in_fmt;
  // Stream from the buffer (buffer-to-bus direction).
  assign buf_out_ready = busy && dir_wr && ack_a && rd_a;
  assign dma_d_out     = out_fmt;
  assign dma_d_oe      = busy && dir_wr;

  assign beat    = (buf_in_valid && buf_in_ready) || (buf_out_ready && buf_out_valid);
  assign req_a   = busy && (dir_wr ? buf_out_valid : buf_in_ready);
  assign dma_req = cfg_pol_req ? req_a : ~req_a;

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dma_d_oe && !buf_in_valid && !buf_out_ready && !beat);

  assert_req_backoff_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !dir_wr && !buf_in_ready |-> dma_req == ~cfg_pol_req);

endmodule

// File: rtl/gdma_port.sv
module gdma_port
  import gdma_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [7:0]          cmd_wdata,
  output logic [7:0]          cmd_rdata,
  input  logic                cfg_wide,
  input  logic                cfg_swap,
  input  logic                cfg_no_count,
  input  logic                cfg_pol_ack,
  input  logic                cfg_pol_req,
  input  logic                cfg_pol_rd,
  input  logic                cfg_pol_wr,
  input  logic                cfg_pol_eot,
  input  logic [CNT_W-1:0]    xfer_count,
  output logic                dma_req,
  input  logic                dma_ack,
  input  logic                dma_rd_stb,
  input  logic                dma_wr_stb,
  input  logic                dma_eot,
  input  logic [2*BYTE_W-1:0] dma_d_in,
  output logic [2*BYTE_W-1:0] dma_d_out,
  output logic                dma_d_oe,
  output logic                buf_in_valid,
  input  logic                buf_in_ready,
  output logic [2*BYTE_W-1:0] buf_in_data,
  input  logic                buf_out_valid,
  output logic                buf_out_ready,
  input  logic [2*BYTE_W-1:0] buf_out_data,
  output logic                buf_validate,
  output logic                irq_int_eot,
  output logic                irq_ext_eot,
  output logic                irq_xfer_ok
);

  logic busy, dir_wr, cnt_load, cnt_last, beat, eot_act;

  assign cmd_rdata = 8'hFF;

  gdma_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(xfer_count),
    .dec(beat), .last(cnt_last)
  );

  gdma_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_wdata),
    .cnt_en(!cfg_no_count), .cnt_zero(xfer_count == '0), .cnt_last(cnt_last),
    .beat(beat), .eot_act(eot_act), .busy(busy), .dir_wr(dir_wr),
    .cnt_load(cnt_load), .irq_int(irq_int_eot), .irq_ext(irq_ext_eot),
    .irq_ok(irq_xfer_ok), .validate(buf_validate)
  );

  gdma_bus_if #(.BYTE_W(BYTE_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dir_wr(dir_wr),
    .cfg_wide(cfg_wide), .cfg_swap(cfg_swap),
    .cfg_pol_ack(cfg_pol_ack), .cfg_pol_req(cfg_pol_req),
    .cfg_pol_rd(cfg_pol_rd), .cfg_pol_wr(cfg_pol_wr), .cfg_pol_eot(cfg_pol_eot),
    .dma_ack(dma_ack), .dma_rd_stb(dma_rd_stb), .dma_wr_stb(dma_wr_stb),
    .dma_eot(dma_eot), .dma_d_in(dma_d_in), .dma_req(dma_req),
    .dma_d_out(dma_d_out), .dma_d_oe(dma_d_oe),
    .buf_in_ready(buf_in_ready), .buf_in_valid(buf_in_valid), .buf_in_data(buf_in_data),
    .buf_out_valid(buf_out_valid), .buf_out_data(buf_out_data),
    .buf_out_ready(buf_out_ready), .beat(beat), .eot_act(eot_act)
  );

  assert_oe_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_d_oe |-> !buf_in_valid);

endmodule

// File: tb/tb_gdma_port.sv
module tb_gdma_port;

  // 100 MHz: period 10 time units (ns).
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_wr = 0;
  logic [7:0]  cmd_wdata = 0;
  logic [7:0]  cmd_rdata;
  logic        cfg_wide = 1, cfg_swap = 0, cfg_no_count = 0;
  logic        cfg_pol_ack = 1, cfg_pol_req = 1, cfg_pol_rd = 1, cfg_pol_wr = 1, cfg_pol_eot = 1;
  logic [15:0] xfer_count = 0;
  logic        dma_req, dma_d_oe, buf_in_valid, buf_out_ready, buf_validate;
  logic        irq_int_eot, irq_ext_eot, irq_xfer_ok;
  logic [15:0] dma_d_in = 0, dma_d_out, buf_in_data, buf_out_data = 0;
  logic        buf_in_ready = 1, buf_out_valid = 1;

  // Logical (active) levels driven by the bench; pins follow the polarities.
  logic ack_a = 0, rd_a = 0, wr_a = 0, eot_a = 0;
  logic dma_ack, dma_rd_stb, dma_wr_stb, dma_eot;
  assign dma_ack    = cfg_pol_ack ? ack_a : ~ack_a;
  assign dma_rd_stb = cfg_pol_rd  ? rd_a  : ~rd_a;
  assign dma_wr_stb = cfg_pol_wr  ? wr_a  : ~wr_a;
  assign dma_eot    = cfg_pol_eot ? eot_a : ~eot_a;

  gdma_port dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .cfg_wide(cfg_wide), .cfg_swap(cfg_swap), .cfg_no_count(cfg_no_count),
    .cfg_pol_ack(cfg_pol_ack), .cfg_pol_req(cfg_pol_req), .cfg_pol_rd(cfg_pol_rd),
    .cfg_pol_wr(cfg_pol_wr), .cfg_pol_eot(cfg_pol_eot), .xfer_count(xfer_count),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_rd_stb(dma_rd_stb), .dma_wr_stb(dma_wr_stb),
    .dma_eot(dma_eot), .dma_d_in(dma_d_in), .dma_d_out(dma_d_out), .dma_d_oe(dma_d_oe),
    .buf_in_valid(buf_in_valid), .buf_in_ready(buf_in_ready), .buf_in_data(buf_in_data),
    .buf_out_valid(buf_out_valid), .buf_out_ready(buf_out_ready), .buf_out_data(buf_out_data),
    .buf_validate(buf_validate), .irq_int_eot(irq_int_eot), .irq_ext_eot(irq_ext_eot),
    .irq_xfer_ok(irq_xfer_ok)
  );

  int checks = 0, failures = 0;
  bit cmp_on = 0, rnd_buf = 0;

  // Reference model state.
  bit m_busy = 0, m_dir = 0, m_int = 0, m_ext = 0, m_ok = 0, m_val = 0;
  logic [15:0] m_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [15:0] w);
    if (!cfg_wide) return {8'h00, w[7:0]};
    if (cfg_swap)  return {w[7:0], w[15:8]};
    return w;
  endfunction

  function automatic bit exp_req_pin();
    bit act;
    act = m_busy && (m_dir ? buf_out_valid : buf_in_ready);
    return cfg_pol_req ? act : !act;
  endfunction

  task automatic compare();
    bit ein, eout;
    ein  = m_busy && !m_dir && ack_a && wr_a;
    eout = m_busy && m_dir && ack_a && rd_a;
    chk(cmd_rdata == 8'hFF, "R1 cmd_rdata", cmd_rdata, 8'hFF);
    chk(dma_d_oe == (m_busy && m_dir), "R7 dma_d_oe", dma_d_oe, m_busy && m_dir);
    chk(dma_req == exp_req_pin(), "R13 dma_req", dma_req, exp_req_pin());
    chk(buf_in_valid == ein, "R2 buf_in_valid", buf_in_valid, ein);
    if (ein) chk(buf_in_data == fmt(dma_d_in), "R8 buf_in_data", buf_in_data, fmt(dma_d_in));
    chk(buf_out_ready == eout, "R3 buf_out_ready", buf_out_ready, eout);
    if (m_busy && m_dir) chk(dma_d_out == fmt(buf_out_data), "R8 dma_d_out", dma_d_out, fmt(buf_out_data));
    chk(irq_int_eot == m_int, "R10 irq_int_eot", irq_int_eot, m_int);
    chk(irq_ext_eot == m_ext, "R12 irq_ext_eot", irq_ext_eot, m_ext);
    chk(irq_xfer_ok == m_ok, "R14 irq_xfer_ok", irq_xfer_ok, m_ok);
    chk(buf_validate == m_val, "R5 buf_validate", buf_validate, m_val);
  endtask

  task automatic model_update();
    bit beat, cen, tc, te;
    if (!rst_n) begin
      m_busy = 0; m_dir = 0; m_int = 0; m_ext = 0; m_ok = 0; m_val = 0; m_cnt = 0;
      return;
    end
    cen  = !cfg_no_count;
    beat = m_busy && ack_a && (m_dir ? (rd_a && buf_out_valid) : (wr_a && buf_in_ready));
    m_val = cmd_wr && cmd_wdata == 8'h0E;
    if (cmd_wr && cmd_wdata <= 8'h01) begin
      m_dir = cmd_wdata[0];
      m_cnt = xfer_count;
      m_ext = 0;
      if (cen && xfer_count == 0) begin m_busy = 0; m_int = 1; m_ok = 1; end
      else begin m_busy = 1; m_int = 0; m_ok = 0; end
    end else if (cmd_wr && cmd_wdata == 8'h0F) begin
      if (beat) m_cnt = m_cnt - 1;
      m_busy = 0;
    end else if (m_busy) begin
      tc = beat && cen && m_cnt == 1;
      te = eot_a;
      if (beat) m_cnt = m_cnt - 1;
      if (tc) m_int = 1;
      if (te) m_ext = 1;
      if (tc || te) begin m_busy = 0; m_ok = 1; end
    end
  endtask

  task automatic tick();
    if (rnd_buf) begin
      buf_in_ready  = ($urandom % 4) != 0;
      buf_out_valid = ($urandom % 4) != 0;
    end
    dma_d_in     = 16'($urandom);
    buf_out_data = 16'($urandom);
    #1;
    if (cmp_on) compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    cmd_wr = 1; cmd_wdata = op;
    tick();
    cmd_wr = 0;
  endtask

  // One strobe pulse in the current direction, then one idle cycle.
  task automatic pulse(input bit with_eot);
    ack_a = 1;
    if (m_dir) rd_a = 1; else wr_a = 1;
    eot_a = with_eot;
    tick();
    rd_a = 0; wr_a = 0; eot_a = 0;
    tick();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    cmp_on = 1;
    // Reset state.
    chk(dma_d_oe == 0 && irq_xfer_ok == 0, "R7 reset oe/flags", {dma_d_oe, irq_xfer_ok}, 0);
    chk(cmd_rdata == 8'hFF, "R1 read after reset", cmd_rdata, 8'hFF);

    // Reserved opcodes while idle.
    for (int op = 2; op <= 13; op++) cmd(8'(op));
    tick();
    chk(dma_d_oe == 0 && irq_xfer_ok == 0 && irq_int_eot == 0, "R4 idle reserved",
        {dma_d_oe, irq_xfer_ok, irq_int_eot}, 0);

    // Validate pulse.
    cmd(8'h0E);
    chk(buf_validate == 1, "R5 validate pulse", buf_validate, 1);
    tick();
    chk(buf_validate == 0, "R5 validate single", buf_validate, 0);

    // Bus-to-buffer, 16-bit, count 4, active-high.
    xfer_count = 4;
    cmd(8'h00);
    repeat (4) pulse(0);
    chk(irq_int_eot && irq_xfer_ok && !irq_ext_eot, "R10 count end",
        {irq_int_eot, irq_ext_eot, irq_xfer_ok}, 3'b101);

    // Buffer-to-bus, 8-bit, active-low everything, count 3, reserved in flight.
    cfg_wide = 0; cfg_pol_ack = 0; cfg_pol_req = 0; cfg_pol_rd = 0; cfg_pol_wr = 0; cfg_pol_eot = 0;
    xfer_count = 3;
    cmd(8'h01);
    chk(dma_req == 0, "R9 active-low request", dma_req, 0);
    cmd(8'h05);
    chk(dma_d_oe == 1, "R4 reserved in flight", dma_d_oe, 1);
    chk(dma_d_out[15:8] == 8'h00, "R8 narrow upper zero", dma_d_out, {8'h00, dma_d_out[7:0]});
    repeat (3) pulse(0);
    chk(dma_d_oe == 0, "R7 oe released", dma_d_oe, 0);

    // 16-bit swap, bus-to-buffer.
    cfg_wide = 1; cfg_swap = 1;
    cfg_pol_ack = 1; cfg_pol_req = 1; cfg_pol_rd = 1; cfg_pol_wr = 1; cfg_pol_eot = 1;
    xfer_count = 2;
    cmd(8'h00);
    repeat (2) pulse(0);

    // Counter disabled: beats past count, then EOT.
    cfg_no_count = 1; xfer_count = 2;
    cmd(8'h01);
    repeat (5) pulse(0);
    chk(dma_d_oe == 1, "R11 counter ignored", dma_d_oe, 1);
    pulse(1);
    chk(irq_ext_eot && !irq_int_eot && irq_xfer_ok, "R12 ext end",
        {irq_int_eot, irq_ext_eot, irq_xfer_ok}, 3'b011);
    cfg_no_count = 0;

    // EOT together with the last counted beat.
    xfer_count = 2;
    cmd(8'h00);
    pulse(0);
    pulse(1);
    chk(irq_ext_eot && irq_int_eot && irq_xfer_ok, "R12 simultaneous end",
        {irq_int_eot, irq_ext_eot, irq_xfer_ok}, 3'b111);

    // Stop mid transfer.
    xfer_count = 10;
    cmd(8'h01);
    pulse(0);
    cmd(8'h0F);
    chk(dma_d_oe == 0 && dma_req == 0 && !irq_xfer_ok, "R6 stop",
        {dma_d_oe, dma_req, irq_xfer_ok}, 0);

    // Zero count.
    xfer_count = 0;
    cmd(8'h00);
    chk(irq_int_eot && irq_xfer_ok && dma_d_oe == 0, "R10 zero count",
        {irq_int_eot, irq_xfer_ok}, 2'b11);

    // Request backs off when the buffer is full.
    xfer_count = 5;
    cmd(8'h00);
    buf_in_ready = 0;
    tick();
    chk(dma_req == 0, "R13 full buffer", dma_req, 0);
    buf_in_ready = 1;
    tick();
    chk(dma_req == 1, "R13 space again", dma_req, 1);

    // Random phase.
    rnd_buf = 1;
    for (int i = 0; i < 4000; i++) begin
      cmd_wr       = ($urandom % 25) == 0;
      cmd_wdata    = 8'($urandom % 16);
      xfer_count   = 16'($urandom % 7);
      if (cmd_wr) begin
        cfg_wide = 1'($urandom); cfg_swap = 1'($urandom); cfg_no_count = ($urandom % 4) == 0;
        cfg_pol_ack = 1'($urandom); cfg_pol_req = 1'($urandom); cfg_pol_rd = 1'($urandom);
        cfg_pol_wr = 1'($urandom); cfg_pol_eot = 1'($urandom);
      end
      ack_a = ($urandom % 4) != 0;
      rd_a  = 1'($urandom);
      wr_a  = 1'($urandom);
      eot_a = ($urandom % 40) == 0;
      tick();
    end
    cmd_wr = 0;
    tick();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule